// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits between the interrupt sources of a small processor subsystem and the sequencer in the core that takes exceptions. It gathers a bank of external request lines (32 by default) and three system exceptions: a non-maskable request, a fault request and a supervisor-call request. It keeps a pending bit and a programmable 2-bit priority for each source, plus an enable for each external line. From that state it picks one winner each cycle and tells the core whether that winner should preempt the handler now running.

The core acknowledges a preemption with a one-cycle pulse. The winner then becomes active and its priority becomes the current execution priority. A one-cycle exception-return pulse retires the most urgent active handler and restores the level it had interrupted. Preemption needs a strictly more urgent priority. Each urgency level can hold at most one active handler, so nesting is tracked as one slot per level.

A narrow write port programs the enables, the priorities and the software pending set and clear. Priorities are reported in two's complement. The two fixed system exceptions sit below zero, and "no handler running" reads as one step less urgent than the least urgent programmable level.

Top module: `irqNestArbiter`

## Requirements
- R1: After reset every enable is 0, every priority is 0 and nothing is pending or active: takeReq is 0, excNum is 0, curNum is 0 and curPrio reads 4 (binary 0100, the "none" level).
- R2: If irqLines[n] is high at a rising clock edge, interrupt n becomes pending. It is reported as exception number 16+n. It stays pending after the line falls, until it is acknowledged or cleared by software.
- R3: Writing address 0 sets the enables whose wrData bits are 1. Writing address 1 clears them. A disabled interrupt keeps its pending bit but never wins.
- R4: Writing address 8+k loads the priority of interrupt 16k+j from wrData[2j+1:2j]. Writing address 4 loads the supervisor-call priority from wrData[1:0]. Level 0 is the most urgent and level 3 the least. An external winner always reports excPrio in the range 0 to 3.
- R5: nmiReq and faultReq are always enabled. They report exception numbers 2 and 3 with fixed priorities -2 (4'hE) and -1 (4'hF), so they outrank every programmable level. svcReq reports exception number 11.
- R6: Among the enabled pending requests, the most urgent priority wins. On equal priority the lower exception number wins.
- R7: takeReq is 1 only when the winner's priority is strictly more urgent than curPrio. While takeReq is 0, excNum reads 0 and excPrio reads 4.
- R8: ackIn with takeReq high and retIn low clears the winner's pending bit, and from the next cycle curNum and curPrio show that winner. ackIn while takeReq is low changes nothing.
- R9: retIn retires the most urgent active handler, and the next cycle shows the handler it had interrupted (or 0 and 4 in thread mode). When retIn and ackIn are high together the acknowledge is ignored. retIn in thread mode has no effect.
- R10: Writing address 2 sets pending bits, and writing address 3 clears them, for the external interrupts whose wrData bits are 1. A set from a line or a write takes precedence over a clear in the same cycle.
- R11: All outputs come from registered state. The result of inputs sampled at an edge shows on the outputs in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | NUM_IRQ | External request lines, sampled each edge |
| nmiReq | input | 1 | Non-maskable request (exception 2) |
| faultReq | input | 1 | Fault request (exception 3) |
| svcReq | input | 1 | Supervisor-call request (exception 11) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 32 | Register write data |
| ackIn | input | 1 | Core accepts the presented winner |
| retIn | input | 1 | Core returns from the current handler |
| takeReq | output | 1 | Winner should preempt now |
| excNum | output | NUM_W | Exception number of the winner |
| excPrio | output | PRIO_W | Winner priority, two's complement |
| curNum | output | NUM_W | Exception number of the running handler, 0 in thread mode |
| curPrio | output | PRIO_W | Current execution priority, two's complement |

## Verification
The bench goes after equal-priority ties, where a design that compared with "less or equal" would let a later request preempt a running handler of the same level or pick the higher exception number. It pulses fault while NMI is active and then returns, which exposes a design that lets a fixed exception be outranked or that loses the pending fault across the return. It drives acknowledge and return in the same cycle and return in thread mode, where a wrong design would push and pop at once or underflow the nesting slots. It also disables a pending line and re-enables it, which catches a design that drops the pending bit with the enable.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic       enSet;
    logic       enClr;
    logic       pendSet;
    logic       pendClr;
    logic       svcPrioWr;
    logic       prioWr;
    logic [2:0] prioIdx;
    logic       ackTake;
    logic       retPop;
  } arbStrobeT;
endpackage

// File: rtl/irqArbControl.sv
module irqArbControl
  import irqArbPkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              ackIn,
  input  logic              retIn,
  input  logic              takeReq,
  input  logic              anyActive,
  output arbStrobeT         strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      if (wrAddr[3]) begin
        strobe.prioWr  = 1'b1;
        strobe.prioIdx = wrAddr[2:0];
      end else begin
        case (wrAddr[2:0])
          3'd0:    strobe.enSet     = 1'b1;
          3'd1:    strobe.enClr     = 1'b1;
          3'd2:    strobe.pendSet   = 1'b1;
          3'd3:    strobe.pendClr   = 1'b1;
          3'd4:    strobe.svcPrioWr = 1'b1;
          default: ;
        endcase
      end
    end
    // return has precedence: an acknowledge in the same cycle is dropped
    strobe.ackTake = ackIn & takeReq & ~retIn;
    strobe.retPop  = retIn & anyActive;
  end
endmodule

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  arbStrobeT                         st,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [NUM_IRQ-1:0]                irqLines,
  input  logic                              nmiReq,
  input  logic                              faultReq,
  input  logic                              svcReq,
  output logic                              takeReq,
  output logic [$clog2(16+NUM_IRQ)-1:0]     excNum,
  output logic [$clog2((1<<PRIO_BITS)+3):0] excPrio,
  output logic [$clog2(16+NUM_IRQ)-1:0]     curNum,
  output logic [$clog2((1<<PRIO_BITS)+3):0] curPrio,
  output logic                              anyActive
);
  localparam int NUM_LVL  = 1 << PRIO_BITS;
  localparam int NUM_RANK = NUM_LVL + 2;           // two fixed ranks on top
  localparam int RANK_W   = $clog2(NUM_RANK + 1);
  localparam int PRIO_W   = RANK_W + 1;
  localparam int NUM_W    = $clog2(16 + NUM_IRQ);
  localparam int PER_WORD = DATA_W / PRIO_BITS;
  localparam logic [RANK_W-1:0] RANK_NONE = RANK_W'(NUM_RANK);

  logic [NUM_IRQ-1:0]   enReg, pendReg, pendNext;
  logic [PRIO_BITS-1:0] prioReg [NUM_IRQ];
  logic [PRIO_BITS-1:0] svcPrio;
  logic                 nmiPend, faultPend, svcPend;
  logic [NUM_RANK-1:0]  actMask;
  logic [NUM_W-1:0]     actNum [NUM_RANK];

  logic [RANK_W-1:0] bestRank, curRank;
  logic [NUM_W-1:0]  bestNum, curNumW;

  function automatic logic [PRIO_W-1:0] toPrio(input logic [RANK_W-1:0] r);
    return PRIO_W'(r) - PRIO_W'(2);
  endfunction

  // winner search in ascending exception-number order, strict compare keeps
  // the lower number on a tie
  always_comb begin
    bestRank = RANK_NONE;
    bestNum  = '0;
    if (nmiPend) begin
      bestRank = RANK_W'(0);
      bestNum  = NUM_W'(2);
    end else if (faultPend) begin
      bestRank = RANK_W'(1);
      bestNum  = NUM_W'(3);
    end
    if (svcPend && (RANK_W'(svcPrio) + RANK_W'(2)) < bestRank) begin
      bestRank = RANK_W'(svcPrio) + RANK_W'(2);
      bestNum  = NUM_W'(11);
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pendReg[i] && enReg[i] && (RANK_W'(prioReg[i]) + RANK_W'(2)) < bestRank) begin
        bestRank = RANK_W'(prioReg[i]) + RANK_W'(2);
        bestNum  = NUM_W'(16 + i);
      end
    end
  end

  // most urgent active slot gives the execution priority
  always_comb begin
    curRank = RANK_NONE;
    curNumW = '0;
    for (int r = NUM_RANK - 1; r >= 0; r--) begin
      if (actMask[r]) begin
        curRank = RANK_W'(r);
        curNumW = actNum[r];
      end
    end
  end

  assign takeReq   = bestRank < curRank;
  assign excNum    = takeReq ? bestNum : '0;
  assign excPrio   = takeReq ? toPrio(bestRank) : toPrio(RANK_NONE);
  assign curNum    = curNumW;
  assign curPrio   = toPrio(curRank);
  assign anyActive = |actMask;

  always_comb begin
    pendNext = pendReg;
    if (st.pendClr) pendNext = pendNext & ~wrData[NUM_IRQ-1:0];
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (st.ackTake && bestNum == NUM_W'(16 + i)) pendNext[i] = 1'b0;
    end
    pendNext = pendNext | irqLines | (st.pendSet ? wrData[NUM_IRQ-1:0] : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= '0;
      pendReg   <= '0;
      svcPrio   <= '0;
      nmiPend   <= 1'b0;
      faultPend <= 1'b0;
      svcPend   <= 1'b0;
      actMask   <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prioReg[i] <= '0;
      for (int r = 0; r < NUM_RANK; r++) actNum[r] <= '0;
    end else begin
      if (st.enSet)      enReg <= enReg | wrData[NUM_IRQ-1:0];
      else if (st.enClr) enReg <= enReg & ~wrData[NUM_IRQ-1:0];
      pendReg   <= pendNext;
      nmiPend   <= nmiReq   | (nmiPend   & ~(st.ackTake && bestNum == NUM_W'(2)));
      faultPend <= faultReq | (faultPend & ~(st.ackTake && bestNum == NUM_W'(3)));
      svcPend   <= svcReq   | (svcPend   & ~(st.ackTake && bestNum == NUM_W'(11)));
      if (st.svcPrioWr) svcPrio <= wrData[PRIO_BITS-1:0];
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (st.prioWr && (i / PER_WORD) == int'(st.prioIdx))
          prioReg[i] <= wrData[(i % PER_WORD)*PRIO_BITS +: PRIO_BITS];
      end
      if (st.ackTake) begin
        actMask[bestRank] <= 1'b1;
        actNum[bestRank]  <= bestNum;
      end else if (st.retPop) begin
        actMask[curRank] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqNestArbiter.sv
module irqNestArbiter
  import irqArbPkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2,
  localparam int NUM_W    = $clog2(16 + NUM_IRQ),
  localparam int PRIO_W   = $clog2((1 << PRIO_BITS) + 3) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               nmiReq,
  input  logic               faultReq,
  input  logic               svcReq,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               ackIn,
  input  logic               retIn,
  output logic               takeReq,
  output logic [NUM_W-1:0]   excNum,
  output logic [PRIO_W-1:0]  excPrio,
  output logic [NUM_W-1:0]   curNum,
  output logic [PRIO_W-1:0]  curPrio
);
  arbStrobeT strobe;
  logic      anyActive;

  irqArbControl uCtrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ackIn    (ackIn),
    .retIn    (retIn),
    .takeReq  (takeReq),
    .anyActive(anyActive),
    .strobe   (strobe)
  );

  irqArbDatapath #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobe),
    .wrData   (wrData),
    .irqLines (irqLines),
    .nmiReq   (nmiReq),
    .faultReq (faultReq),
    .svcReq   (svcReq),
    .takeReq  (takeReq),
    .excNum   (excNum),
    .excPrio  (excPrio),
    .curNum   (curNum),
    .curPrio  (curPrio),
    .anyActive(anyActive)
  );
endmodule

// File: rtl/irqArbChecker.sv
module irqArbChecker #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2,
  localparam int NUM_W    = $clog2(16 + NUM_IRQ),
  localparam int PRIO_W   = $clog2((1 << PRIO_BITS) + 3) + 1,
  localparam int NUM_LVL  = 1 << PRIO_BITS
) (
  input logic              clk,
  input logic              rstN,
  input logic              ackIn,
  input logic              retIn,
  input logic              takeReq,
  input logic [NUM_W-1:0]  excNum,
  input logic [PRIO_W-1:0] excPrio,
  input logic [NUM_W-1:0]  curNum,
  input logic [PRIO_W-1:0] curPrio
);
  AST_THREAD_NONE: assert property (@(posedge clk) disable iff (!rstN)
    curNum == '0 |-> curPrio == PRIO_W'(NUM_LVL)); // R1
  AST_IRQ_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && excNum >= NUM_W'(16)) |-> (!excPrio[PRIO_W-1] && excPrio < PRIO_W'(NUM_LVL))); // R4
  AST_NMI_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && excNum == NUM_W'(2)) |-> excPrio == PRIO_W'(-2)); // R5
  AST_FAULT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && excNum == NUM_W'(3)) |-> excPrio == PRIO_W'(-1)); // R5
  AST_TAKE_STRICT: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> ($signed(excPrio) < $signed(curPrio))); // R7
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !takeReq |-> (excNum == '0 && excPrio == PRIO_W'(NUM_LVL))); // R7
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && takeReq && !retIn) |=> (curNum == $past(excNum) && curPrio == $past(excPrio))); // R8
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !takeReq && !retIn) |=> $stable(curNum)); // R8
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rstN)
    (retIn && curNum != '0) |=> ($signed(curPrio) > $signed($past(curPrio)))); // R9
  AST_RET_THREAD: assert property (@(posedge clk) disable iff (!rstN)
    (retIn && curNum == '0) |=> curNum == '0); // R9
endmodule

bind irqNestArbiter irqArbChecker #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) uChk (.*);

// File: tb/tb_irqNestArbiter.sv
module tb_irqNestArbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic        nmiReq = 1'b0, faultReq = 1'b0, svcReq = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        ackIn = 1'b0, retIn = 1'b0;
  logic        takeReq;
  logic [5:0]  excNum, curNum;
  logic [3:0]  excPrio, curPrio;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // bench model
  int mEn[32], mPend[32], mPrio[32];
  int mSvcPrio, mNmi, mFault, mSvc;
  int stkNum[8], stkRank[8];
  int depth;

  irqNestArbiter dut (.*);

  always #4 clk = ~clk;   // 125 MHz

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void bestOf(output int r, output int n);
    r = 6; n = 0;
    if (mNmi != 0) begin r = 0; n = 2; end
    else if (mFault != 0) begin r = 1; n = 3; end
    if (mSvc != 0 && mSvcPrio + 2 < r) begin r = mSvcPrio + 2; n = 11; end
    for (int i = 0; i < 32; i++)
      if (mPend[i] != 0 && mEn[i] != 0 && mPrio[i] + 2 < r) begin r = mPrio[i] + 2; n = 16 + i; end
  endfunction

  function automatic int curR();
    return (depth > 0) ? stkRank[depth-1] : 6;
  endfunction

  task automatic compareAll();
    int br, bn, cr, expNum, expPrio, expCur, expCurP;
    bit t;
    bestOf(br, bn);
    cr = curR();
    t = br < cr;
    expNum = t ? bn : 0;
    expPrio = t ? br - 2 : 4;
    expCur = (depth > 0) ? stkNum[depth-1] : 0;
    expCurP = cr - 2;
    chk(takeReq == t, "R6 takeReq", int'(takeReq), int'(t));
    chk(int'(excNum) == expNum, "R6 excNum", int'(excNum), expNum);
    chk(int'($signed(excPrio)) == expPrio, "R6 excPrio", int'($signed(excPrio)), expPrio);
    chk(int'(curNum) == expCur, "R9 curNum", int'(curNum), expCur);
    chk(int'($signed(curPrio)) == expCurP, "R9 curPrio", int'($signed(curPrio)), expCurP);
  endtask

  // apply current inputs to model, advance one clock, compare at negedge
  task automatic cycle();
    int br, bn;
    bit t, ackEff, retEff;
    bestOf(br, bn);
    t = br < curR();
    ackEff = ackIn && t && !retIn;
    retEff = retIn && depth > 0;
    for (int i = 0; i < 32; i++) begin
      if (wrEn && wrAddr == 4'd3 && wrData[i]) mPend[i] = 0;
      if (ackEff && bn == 16 + i) mPend[i] = 0;
      if (irqLines[i] || (wrEn && wrAddr == 4'd2 && wrData[i])) mPend[i] = 1;
      if (wrEn && wrAddr == 4'd0 && wrData[i]) mEn[i] = 1;
      if (wrEn && wrAddr == 4'd1 && wrData[i]) mEn[i] = 0;
      if (wrEn && wrAddr == 4'd8 && i < 16) mPrio[i] = int'((wrData >> (2*i)) & 32'd3);
      if (wrEn && wrAddr == 4'd9 && i >= 16) mPrio[i] = int'((wrData >> (2*(i-16))) & 32'd3);
    end
    if (wrEn && wrAddr == 4'd4) mSvcPrio = int'(wrData & 32'd3);
    mNmi   = nmiReq   ? 1 : ((ackEff && bn == 2)  ? 0 : mNmi);
    mFault = faultReq ? 1 : ((ackEff && bn == 3)  ? 0 : mFault);
    mSvc   = svcReq   ? 1 : ((ackEff && bn == 11) ? 0 : mSvc);
    if (ackEff) begin stkNum[depth] = bn; stkRank[depth] = br; depth++; end
    else if (retEff) depth--;
    @(posedge clk);
    cycles++;
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cycle();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic expect3(input string tag, input bit t, input int n, input int p);
    chk(takeReq == t, tag, int'(takeReq), int'(t));
    chk(int'(excNum) == n, tag, int'(excNum), n);
    chk(int'($signed(excPrio)) == p, tag, int'($signed(excPrio)), p);
  endtask

  task automatic expectCur(input string tag, input int n, input int p);
    chk(int'(curNum) == n, tag, int'(curNum), n);
    chk(int'($signed(curPrio)) == p, tag, int'($signed(curPrio)), p);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mEn[i] = 0; mPend[i] = 0; mPrio[i] = 0; end
    mSvcPrio = 0; mNmi = 0; mFault = 0; mSvc = 0; depth = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expect3("R1 reset outputs", 1'b0, 0, 4);
    expectCur("R1 reset current", 0, 4);

    wr(4'd0, 32'h20);                                  // enable irq5
    irqLines = 32'h20; cycle(); irqLines = '0;
    expect3("R2 R11 line pulse", 1'b1, 21, 0);
    cycle();
    expect3("R2 pending held", 1'b1, 21, 0);
    wr(4'd1, 32'h20);
    expect3("R3 disabled never wins", 1'b0, 0, 4);
    wr(4'd0, 32'h20);
    expect3("R3 pending kept", 1'b1, 21, 0);
    wr(4'd3, 32'h20);
    expect3("R10 software clear", 1'b0, 0, 4);

    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd8, 32'h80);                                  // irq3 -> level 2
    wr(4'd9, 32'h100);                                 // irq20 -> level 1
    wr(4'd2, 32'h0010_0008);
    expect3("R4 R10 priority fields", 1'b1, 36, 1);
    wr(4'd2, 32'h80);
    expect3("R6 more urgent wins", 1'b1, 23, 0);
    wr(4'd2, 32'h10);
    expect3("R6 tie lower number", 1'b1, 20, 0);

    ackIn = 1'b1; cycle(); ackIn = 1'b0;
    expectCur("R8 ack activates", 20, 0);
    expect3("R7 equal level no preempt", 1'b0, 0, 4);
    ackIn = 1'b1; cycle(); ackIn = 1'b0;
    expectCur("R8 ack without take ignored", 20, 0);

    nmiReq = 1'b1; cycle(); nmiReq = 1'b0;
    expect3("R5 nmi fixed", 1'b1, 2, -2);
    ackIn = 1'b1; cycle(); ackIn = 1'b0;
    expectCur("R5 nmi active", 2, -2);
    faultReq = 1'b1; cycle(); faultReq = 1'b0;
    expect3("R7 fault below nmi", 1'b0, 0, 4);
    retIn = 1'b1; cycle(); retIn = 1'b0;
    expectCur("R9 return restores", 20, 0);
    expect3("R5 fault fixed", 1'b1, 3, -1);
    ackIn = 1'b1; retIn = 1'b1; cycle(); ackIn = 1'b0; retIn = 1'b0;
    expectCur("R9 ack dropped on return", 0, 4);
    expect3("R9 fault still pending", 1'b1, 3, -1);
    ackIn = 1'b1; cycle(); ackIn = 1'b0;
    retIn = 1'b1; cycle(); retIn = 1'b0;
    retIn = 1'b1; cycle(); retIn = 1'b0;
    expectCur("R9 return in thread ignored", 0, 4);
    svcReq = 1'b1; cycle(); svcReq = 1'b0;
    expect3("R4 svc beats irq on tie", 1'b1, 11, 0);
    wr(4'd4, 32'h3);
    expect3("R4 svc level 3 loses", 1'b1, 23, 0);

    for (int k = 0; k < 4000; k++) begin
      irqLines = $urandom & $urandom & $urandom & $urandom;
      nmiReq   = ($urandom % 64) == 0;
      faultReq = ($urandom % 32) == 0;
      svcReq   = ($urandom % 16) == 0;
      wrEn     = ($urandom % 4) == 0;
      case ($urandom % 8)
        0: wrAddr = 4'd0;  1: wrAddr = 4'd1;  2: wrAddr = 4'd2;  3: wrAddr = 4'd3;
        4: wrAddr = 4'd4;  5: wrAddr = 4'd8;  6: wrAddr = 4'd9;  default: wrAddr = 4'd5;
      endcase
      wrData = (wrAddr == 4'd1 || wrAddr == 4'd3) ? ($urandom & $urandom & $urandom) : $urandom;
      ackIn = ($urandom % 2) == 0;
      retIn = ($urandom % 5) == 0;
      cycle();
    end
    irqLines = '0; nmiReq = 0; faultReq = 0; svcReq = 0; wrEn = 0; ackIn = 0; retIn = 0;
    cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=%0d expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule